// File: doc/BRIEF.md
# TFT Panel Raster Timing Generator

This block produces the raster timing for a parallel RGB TFT panel. It divides the incoming LCD clock down to a pixel clock with an even duty cycle. Two phase machines run on that pixel clock, one per axis. Each machine steps through a sync pulse, a start wait, the active region and an end wait, and then wraps to the sync pulse. From these machines the block drives the horizontal and vertical sync outputs, a data-enable strobe and the pixel clock. It also drives a one-cycle pixel-request strobe that tells an upstream pixel source when to present the next pixel, and it reports the zero-based coordinates of the pixel currently on the output.

Every interval length is a field that holds the interval length minus one. The divisor sets the length of each pixel-clock half-period in LCD clocks. The configuration inputs are treated as quasi-static: the block samples them during reset and again at the first LCD clock of each new frame, so a change in the middle of a frame takes effect only at the next frame boundary.

The horizontal machine and the vertical machine have the same four states: `PH_SYNC`, `PH_START`, `PH_ACTIVE` and `PH_END`. A machine leaves its current state when its interval counter reaches that state's limit while it is stepped. The transitions are SYNC→START, START→ACTIVE, ACTIVE→END and END→SYNC, and the last one is the wrap. The horizontal machine is stepped at each falling edge of the pixel clock. The vertical machine is stepped when the horizontal machine wraps. The clock divider has two states, `HALF_LO` and `HALF_HI`. It toggles between them after each block of `cfg_div` LCD clocks.

Top module: `lcdt_timing_gen`

## Requirements
- R1: `pix_clk` stays low for D LCD clocks and then high for D LCD clocks, repeating. D equals `cfg_div`, and a value of 0 acts as 1. Each pixel period begins with its low half.
- R2: Each line runs these intervals in order: horizontal sync, start wait, active and end wait. Each interval lasts (field+1) pixel clocks, taken from `cfg_h_sync`, `cfg_h_start`, `cfg_h_active` and `cfg_h_end` respectively. The timing outputs change only in the LCD cycle that follows a falling edge of `pix_clk`.
- R3: `hsync` is 1 during the horizontal sync interval and 0 elsewhere. When `cfg_hs_inv` is 1, `hsync` is the inverse of this.
- R4: Each frame runs these intervals in whole lines, in order: vertical sync, start wait, active lines and end wait. Each interval lasts (field+1) lines, taken from `cfg_v_sync`, `cfg_v_start`, `cfg_v_active` and `cfg_v_end` respectively. `vsync` is 1 for the sync lines, and `cfg_vs_inv` inverts it.
- R5: `den` is 1 exactly when the horizontal interval and the vertical interval are both active.
- R6: `pix_req` is 1 for exactly one LCD clock, in the cycle just before each rising edge of `pix_clk`, but only while `den` is 1.
- R7: `x_pos` and `y_pos` give the zero-based column and row inside the active area. Each reads 0 outside its own active interval.
- R8: While `rst` is high, and in the first cycle after it falls, the block sits at the first LCD clock of the first horizontal sync pixel of line 0 of a new frame. In that state `pix_clk` is 0 and `den`, `pix_req`, `x_pos` and `y_pos` are 0.
- R9: All configuration inputs are sampled during reset and at the LCD edge that starts each new frame. A change at any other time has no effect until the next frame starts.
- R10: With every interval field at 0 and `cfg_div` at 0, every interval lasts exactly one unit. A line is then 4 pixels, a frame is 4 lines, and a pixel is 2 LCD clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | LCD clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_div | input | DIVW | Pixel-clock half-period in LCD clocks (0 acts as 1) |
| cfg_h_sync | input | HW | Horizontal sync width minus one |
| cfg_h_start | input | HW | Horizontal start wait minus one |
| cfg_h_active | input | HW | Active pixels per line minus one |
| cfg_h_end | input | HW | Horizontal end wait minus one |
| cfg_v_sync | input | VW | Vertical sync lines minus one |
| cfg_v_start | input | VW | Vertical start wait lines minus one |
| cfg_v_active | input | VW | Active lines per frame minus one |
| cfg_v_end | input | VW | Vertical end wait lines minus one |
| cfg_hs_inv | input | 1 | Invert the horizontal sync polarity |
| cfg_vs_inv | input | 1 | Invert the vertical sync polarity |
| pix_clk | output | 1 | Pixel clock |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| den | output | 1 | Data enable |
| pix_req | output | 1 | Request for the next pixel, one LCD clock before the pixel clock rises |
| x_pos | output | HW | Active-area column |
| y_pos | output | VW | Active-area row |

## Verification
The hardest situation to reach from the ports is a configuration change that arrives in the middle of a frame. The block must keep the old line and frame lengths, the old divisor and the old polarities until the wrap, and switch to the new values at the exact LCD edge where the frame restarts. The stimulus rewrites every field, including the divisor and both inversions, partway through a running frame. The reference model loads its own copy of the configuration only at its own frame wrap, so any early or late pickup appears as a mismatch on the outputs. Further stimulus covers the case where every field is zero, and a reset issued in the middle of a frame with a new configuration already on the inputs.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    typedef enum logic [1:0] {
        PH_SYNC   = 2'd0,
        PH_START  = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_END    = 2'd3
    } phase_e;

    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;

endpackage

// File: rtl/lcdt_clkdiv.sv
module lcdt_clkdiv
    import lcdt_pkg::*;
#(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [DIVW-1:0] div,
    output logic            pclk,
    output logic            rise_tick,
    output logic            fall_tick
);

    localparam logic [DIVW-1:0] ONE = DIVW'(1);

    half_e           half_q, half_d;
    logic [DIVW-1:0] cnt_q, cnt_d;
    logic [DIVW-1:0] div_eff;
    logic            last;

    assign div_eff = (div == '0) ? ONE : div;
    assign last    = (cnt_q == div_eff - ONE);

    always_comb begin
        half_d = half_q;
        cnt_d  = cnt_q + ONE;
        if (last) begin
            cnt_d = '0;
            unique case (half_q)
                HALF_LO: half_d = HALF_HI;
                HALF_HI: half_d = HALF_LO;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q <= HALF_LO;
            cnt_q  <= '0;
        end else begin
            half_q <= half_d;
            cnt_q  <= cnt_d;
        end
    end

    always_comb begin
        pclk      = (half_q == HALF_HI);
        rise_tick = last && (half_q == HALF_LO);
        fall_tick = last && (half_q == HALF_HI);
    end

endmodule

// File: rtl/lcdt_phase_fsm.sv
module lcdt_phase_fsm
    import lcdt_pkg::*;
#(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic [W-1:0] lim_sync,
    input  logic [W-1:0] lim_start,
    input  logic [W-1:0] lim_active,
    input  logic [W-1:0] lim_end,
    output phase_e       phase,
    output logic [W-1:0] cnt,
    output logic         wrap
);

    localparam logic [W-1:0] ONE = W'(1);

    phase_e       phase_d;
    logic [W-1:0] cnt_d;
    logic [W-1:0] lim_cur;
    logic         at_last;

    always_comb begin
        unique case (phase)
            PH_SYNC:   lim_cur = lim_sync;
            PH_START:  lim_cur = lim_start;
            PH_ACTIVE: lim_cur = lim_active;
            PH_END:    lim_cur = lim_end;
        endcase
    end

    assign at_last = (cnt == lim_cur);

    always_comb begin
        phase_d = phase;
        cnt_d   = cnt;
        if (step) begin
            if (at_last) begin
                cnt_d = '0;
                unique case (phase)
                    PH_SYNC:   phase_d = PH_START;
                    PH_START:  phase_d = PH_ACTIVE;
                    PH_ACTIVE: phase_d = PH_END;
                    PH_END:    phase_d = PH_SYNC;
                endcase
            end else begin
                cnt_d = cnt + ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_SYNC;
            cnt   <= '0;
        end else begin
            phase <= phase_d;
            cnt   <= cnt_d;
        end
    end

    assign wrap = step && at_last && (phase == PH_END);

endmodule

// File: rtl/lcdt_timing_gen.sv
module lcdt_timing_gen
    import lcdt_pkg::*;
#(
    parameter int DIVW = 8,
    parameter int HW   = 11,
    parameter int VW   = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [DIVW-1:0] cfg_div,
    input  logic [HW-1:0]   cfg_h_sync,
    input  logic [HW-1:0]   cfg_h_start,
    input  logic [HW-1:0]   cfg_h_active,
    input  logic [HW-1:0]   cfg_h_end,
    input  logic [VW-1:0]   cfg_v_sync,
    input  logic [VW-1:0]   cfg_v_start,
    input  logic [VW-1:0]   cfg_v_active,
    input  logic [VW-1:0]   cfg_v_end,
    input  logic            cfg_hs_inv,
    input  logic            cfg_vs_inv,
    output logic            pix_clk,
    output logic            hsync,
    output logic            vsync,
    output logic            den,
    output logic            pix_req,
    output logic [HW-1:0]   x_pos,
    output logic [VW-1:0]   y_pos
);

    // frame-start shadow of the configuration
    logic [DIVW-1:0] sh_div;
    logic [HW-1:0]   sh_hs, sh_hst, sh_ha, sh_he;
    logic [VW-1:0]   sh_vs, sh_vst, sh_va, sh_ve;
    logic            sh_hinv, sh_vinv;

    logic            rise_tick, fall_tick;
    phase_e          h_phase, v_phase;
    logic [HW-1:0]   h_cnt;
    logic [VW-1:0]   v_cnt;
    logic            h_wrap, v_wrap;
    logic            load;

    assign load = rst || v_wrap;

    always_ff @(posedge clk) begin
        if (load) begin
            sh_div  <= cfg_div;
            sh_hs   <= cfg_h_sync;
            sh_hst  <= cfg_h_start;
            sh_ha   <= cfg_h_active;
            sh_he   <= cfg_h_end;
            sh_vs   <= cfg_v_sync;
            sh_vst  <= cfg_v_start;
            sh_va   <= cfg_v_active;
            sh_ve   <= cfg_v_end;
            sh_hinv <= cfg_hs_inv;
            sh_vinv <= cfg_vs_inv;
        end
    end

    lcdt_clkdiv #(.DIVW(DIVW)) div_i (
        .clk       (clk),
        .rst       (rst),
        .div       (sh_div),
        .pclk      (pix_clk),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    lcdt_phase_fsm #(.W(HW)) hfsm_i (
        .clk        (clk),
        .rst        (rst),
        .step       (fall_tick),
        .lim_sync   (sh_hs),
        .lim_start  (sh_hst),
        .lim_active (sh_ha),
        .lim_end    (sh_he),
        .phase      (h_phase),
        .cnt        (h_cnt),
        .wrap       (h_wrap)
    );

    lcdt_phase_fsm #(.W(VW)) vfsm_i (
        .clk        (clk),
        .rst        (rst),
        .step       (h_wrap),
        .lim_sync   (sh_vs),
        .lim_start  (sh_vst),
        .lim_active (sh_va),
        .lim_end    (sh_ve),
        .phase      (v_phase),
        .cnt        (v_cnt),
        .wrap       (v_wrap)
    );

    always_comb begin
        hsync   = (h_phase == PH_SYNC) ^ sh_hinv;
        vsync   = (v_phase == PH_SYNC) ^ sh_vinv;
        den     = (h_phase == PH_ACTIVE) && (v_phase == PH_ACTIVE);
        pix_req = den && rise_tick;
        x_pos   = (h_phase == PH_ACTIVE) ? h_cnt : '0;
        y_pos   = (v_phase == PH_ACTIVE) ? v_cnt : '0;
    end

endmodule

// File: rtl/lcdt_timing_chk.sv
module lcdt_timing_chk #(
    parameter int HW = 11,
    parameter int VW = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          pix_clk,
    input logic          hsync,
    input logic          vsync,
    input logic          den,
    input logic          pix_req,
    input logic [HW-1:0] x_pos,
    input logic [VW-1:0] y_pos
);

    // R6
    pix_req_rise_chk: assert property (@(posedge clk) disable iff (rst)
        pix_req |=> $rose(pix_clk));

    // R6
    pix_req_den_chk: assert property (@(posedge clk) disable iff (rst)
        pix_req |-> den);

    // R3
    hsync_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(hsync) |-> $fell(pix_clk));

    // R4
    vsync_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(vsync) |-> $fell(pix_clk));

    // R7
    xpos_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(x_pos) |-> $fell(pix_clk));

    // R8
    reset_exit_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pix_clk && !den && !pix_req && x_pos == '0 && y_pos == '0));

endmodule

bind lcdt_timing_gen lcdt_timing_chk #(.HW(HW), .VW(VW)) chk_i (.*);

// File: tb/lcdt_timing_gen_tb_top.sv
module lcdt_timing_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DIVW = 8;
    localparam int HW   = 11;
    localparam int VW   = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [DIVW-1:0] cfg_div = '0;
    logic [HW-1:0]   cfg_h_sync = '0, cfg_h_start = '0, cfg_h_active = '0, cfg_h_end = '0;
    logic [VW-1:0]   cfg_v_sync = '0, cfg_v_start = '0, cfg_v_active = '0, cfg_v_end = '0;
    logic cfg_hs_inv = 1'b0, cfg_vs_inv = 1'b0;

    logic pix_clk, hsync, vsync, den, pix_req;
    logic [HW-1:0] x_pos;
    logic [VW-1:0] y_pos;

    int n_checks = 0;
    int n_fail   = 0;
    string ctx = "";

    always #(CLK_PERIOD/2) clk = ~clk;

    lcdt_timing_gen #(.DIVW(DIVW), .HW(HW), .VW(VW)) dut_i (
        .clk(clk), .rst(rst), .cfg_div(cfg_div),
        .cfg_h_sync(cfg_h_sync), .cfg_h_start(cfg_h_start),
        .cfg_h_active(cfg_h_active), .cfg_h_end(cfg_h_end),
        .cfg_v_sync(cfg_v_sync), .cfg_v_start(cfg_v_start),
        .cfg_v_active(cfg_v_active), .cfg_v_end(cfg_v_end),
        .cfg_hs_inv(cfg_hs_inv), .cfg_vs_inv(cfg_vs_inv),
        .pix_clk(pix_clk), .hsync(hsync), .vsync(vsync), .den(den),
        .pix_req(pix_req), .x_pos(x_pos), .y_pos(y_pos)
    );

    // behavioural reference: pixel index in line, line index in frame
    int m_div, m_hs, m_hst, m_ha, m_he, m_vs, m_vst, m_va, m_ve;
    int m_hinv, m_vinv;
    int sub = 0, half = 0, px = 0, ln = 0;

    task automatic load_model();
        m_div = int'(cfg_div); m_hs = int'(cfg_h_sync); m_hst = int'(cfg_h_start);
        m_ha = int'(cfg_h_active); m_he = int'(cfg_h_end);
        m_vs = int'(cfg_v_sync); m_vst = int'(cfg_v_start);
        m_va = int'(cfg_v_active); m_ve = int'(cfg_v_end);
        m_hinv = int'(cfg_hs_inv); m_vinv = int'(cfg_vs_inv);
    endtask

    function automatic int dval();
        return (m_div == 0) ? 1 : m_div;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            load_model();
            sub = 0; half = 0; px = 0; ln = 0;
        end else if (sub == dval() - 1) begin
            sub = 0;
            if (half == 1) begin
                half = 0;
                px++;
                if (px == m_hs + m_hst + m_ha + m_he + 4) begin
                    px = 0;
                    ln++;
                    if (ln == m_vs + m_vst + m_va + m_ve + 4) begin
                        ln = 0;
                        load_model();
                    end
                end
            end else begin
                half = 1;
            end
        end else begin
            sub++;
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", ctx, tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        int h0, v0, e_hs, e_vs, e_den, e_req, e_x, e_y;
        logic hact, vact;
        h0 = m_hs + m_hst + 2;
        v0 = m_vs + m_vst + 2;
        hact = (px >= h0) && (px < h0 + m_ha + 1);
        vact = (ln >= v0) && (ln < v0 + m_va + 1);
        e_hs  = ((px < m_hs + 1) ? 1 : 0) ^ m_hinv;
        e_vs  = ((ln < m_vs + 1) ? 1 : 0) ^ m_vinv;
        e_den = (hact && vact) ? 1 : 0;
        e_req = (e_den == 1 && half == 0 && sub == dval() - 1) ? 1 : 0;
        e_x   = hact ? px - h0 : 0;
        e_y   = vact ? ln - v0 : 0;
        chk("R1 pix_clk", int'(pix_clk), half);
        chk("R3 hsync", int'(hsync), e_hs);
        chk("R4 vsync", int'(vsync), e_vs);
        chk("R5 den", int'(den), e_den);
        chk("R6 pix_req", int'(pix_req), e_req);
        chk("R2 R7 x_pos", int'(x_pos), e_x);
        chk("R4 R7 y_pos", int'(y_pos), e_y);
        if (rst) begin
            // R8 explicit reset state
            chk("R8 reset pix_clk", int'(pix_clk), 0);
            chk("R8 reset den", int'(den), 0);
        end
    end

    task automatic set_cfg(input int d, input int hs, input int hst, input int ha, input int he,
                           input int vs, input int vst, input int va, input int ve,
                           input int hi, input int vi);
        cfg_div = DIVW'(d);
        cfg_h_sync = HW'(hs); cfg_h_start = HW'(hst); cfg_h_active = HW'(ha); cfg_h_end = HW'(he);
        cfg_v_sync = VW'(vs); cfg_v_start = VW'(vst); cfg_v_active = VW'(va); cfg_v_end = VW'(ve);
        cfg_hs_inv = hi[0]; cfg_vs_inv = vi[0];
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    bit done = 0;

    initial begin
        // R8: reset with a small config, R2 R3 R4 over two frames (80 clocks each)
        ctx = "R8";
        set_cfg(1, 0, 1, 3, 0, 0, 0, 1, 0, 0, 0);
        run(3);
        rst = 1'b0;
        run(2);
        ctx = "R2";
        run(200);
        // R9: mid-frame change of every field; old frame must finish unchanged
        ctx = "R9";
        set_cfg(2, 2, 1, 5, 1, 1, 0, 2, 1, 1, 1);
        run(1200);
        // R10: all-zero fields and divisor
        ctx = "R10";
        set_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        run(600);
        // R8: reset in mid-frame with a new config waiting
        ctx = "R8";
        set_cfg(3, 0, 2, 7, 1, 0, 1, 3, 0, 0, 1);
        rst = 1'b1;
        run(3);
        rst = 1'b0;
        run(1500);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule